// File: doc/BRIEF.md
# Interrupt Context Stack Saver

This block runs the register-save step of interrupt entry. On the cycle an interrupt is accepted it picks one of two stack pointers, takes a snapshot of the 16-bit flag register and the 20-bit program counter, and writes that four-byte image into a byte-addressed stack through a simple write port that waits on a ready handshake. The least significant bit of the chosen pointer sets the bus pattern. An even pointer gives two little-endian 16-bit writes. An odd pointer gives four 8-bit writes.

When the last write is taken, the block raises a one-cycle completion pulse. On that pulse it presents the pointer value minus four and a flag that names which pointer (interrupt or user) has to be updated. Vector fetch, priority arbitration and the restore path sit outside this block.

Top module: `irq_ctx_saver`

## Requirements
- R1: The user stack pointer is selected only when a software interrupt is flagged, its number lies in 32..63, and the user-stack flag is 1. In every other case the interrupt stack pointer is used. `sp_wb_user_o` is 1 for the user pointer and 0 for the interrupt pointer.
- R2: With an even pointer SP, exactly two word writes (`mem_word_o`=1) are issued: first to SP-2, then to SP-4.
- R3: With an odd pointer SP, exactly four byte writes (`mem_word_o`=0) are issued, to SP-1, SP-2, SP-3 and SP-4 in that order.
- R4: The image bytes are as follows. SP-4 holds PC[7:0] and SP-3 holds PC[15:8]. SP-2 holds FLG[7:0]. SP-1 holds {FLG[15:12], PC[19:16]}.
- R5: A word write always has an even address and is little-endian: `mem_wdata_o`[7:0] goes to the even address and [15:8] to the next address. A byte write carries its byte on [7:0], with [15:8] at zero.
- R6: A write is accepted on a rising edge where `mem_wr_o` and `mem_rdy_i` are both 1. While `mem_rdy_i` is 0, the strobe, address, data and size hold steady.
- R7: `done_o` is high for exactly one cycle: the cycle after the last write is accepted. No write is issued in that cycle.
- R8: While `done_o` is high, `sp_wb_o` equals the selected pointer's value at acceptance minus 4, with modulo wrap at the pointer width.
- R9: `accept_i` is ignored while writes are in progress. SP, FLG, PC and the selection inputs are captured on the accept cycle, so later changes to them do not affect the image.
- R10: After reset, `mem_wr_o` and `done_o` are 0 until an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_i | input | 1 | Interrupt accepted strobe |
| swi_valid_i | input | 1 | Interrupt comes from a software interrupt instruction |
| swi_num_i | input | SWI_W | Software interrupt number |
| ustk_sel_i | input | 1 | User-stack select flag |
| isp_i | input | SP_W | Interrupt stack pointer |
| usp_i | input | SP_W | User stack pointer |
| flg_i | input | 16 | Flag register |
| pc_i | input | 20 | Program counter |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | SP_W | Byte address of the write |
| mem_wdata_o | output | 16 | Write data |
| mem_word_o | output | 1 | 1 = 16-bit write, 0 = 8-bit write |
| mem_rdy_i | input | 1 | Memory accepts the write |
| done_o | output | 1 | One-cycle completion pulse |
| sp_wb_o | output | SP_W | Updated pointer value, valid with done_o |
| sp_wb_user_o | output | 1 | Pointer to update: 1 user, 0 interrupt |

## Verification
The bench sweeps every software-interrupt number with both states of the software flag and the user-stack flag. Each case uses pointers of changing parity and a changing number of ready stall cycles. A wrong number bound or a missing qualifier shows up as a wrong `sp_wb_user_o` or a wrong beat address.

Pointers of 0x0001, 0x0002 and 0x0003 exercise wrap below address zero. A design that compared addresses instead of subtracting them would emit broken addresses there.

Runs that wiggle `accept_i`, FLG, PC and the pointers during the writes would expose a design that restarts or samples its inputs late: it would emit extra beats or a mixed image. Stalls catch a design that advances without the ready handshake or that drops the strobe.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int PC_W   = 20;
    localparam int FLG_W  = 16;
    localparam int DATA_W = 16;
    localparam int BEAT_W = 2;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;
endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select #(
    parameter int SP_W   = 16,
    parameter int SWI_W  = 6,
    parameter int SWI_LO = 32,
    parameter int SWI_HI = 63
) (
    input  logic             swi_valid_i,
    input  logic [SWI_W-1:0] swi_num_i,
    input  logic             ustk_sel_i,
    input  logic [SP_W-1:0]  isp_i,
    input  logic [SP_W-1:0]  usp_i,
    output logic             use_user_o,
    output logic [SP_W-1:0]  sp_o
);
    localparam int NUM_W = SWI_W + 1;
    localparam logic [NUM_W-1:0] LO_V = NUM_W'(SWI_LO);
    localparam logic [NUM_W-1:0] HI_V = NUM_W'(SWI_HI);

    logic [NUM_W-1:0] num_ext;
    logic             in_range;

    always_comb begin
        num_ext    = {1'b0, swi_num_i};
        in_range   = (num_ext >= LO_V) && (num_ext <= HI_V);
        use_user_o = swi_valid_i && in_range && ustk_sel_i;
        sp_o       = use_user_o ? usp_i : isp_i;
    end
endmodule

// File: rtl/ctx_beat_gen.sv
module ctx_beat_gen
    import ctx_pkg::*;
#(
    parameter int SP_W = 16
) (
    input  logic [SP_W-1:0]   sp_base_i,
    input  logic              odd_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic [FLG_W-1:0]  flg_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic [SP_W-1:0]   addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              word_o,
    output logic              last_o
);
    logic [7:0] top_byte;
    logic [7:0] flg_lo;
    logic [7:0] pc_lo;
    logic [7:0] pc_mid;

    always_comb begin
        top_byte = {flg_i[FLG_W-1 -: 4], pc_i[PC_W-1 -: 4]};
        flg_lo   = flg_i[7:0];
        pc_lo    = pc_i[7:0];
        pc_mid   = pc_i[15:8];
        word_o   = !odd_i;
        addr_o   = sp_base_i;
        data_o   = '0;
        last_o   = 1'b0;
        if (!odd_i) begin
            // two little-endian halfwords, upper one first
            if (beat_i[0] == 1'b0) begin
                addr_o = sp_base_i - SP_W'(2);
                data_o = {top_byte, flg_lo};
            end else begin
                addr_o = sp_base_i - SP_W'(4);
                data_o = {pc_mid, pc_lo};
                last_o = 1'b1;
            end
        end else begin
            // four bytes walking downward
            addr_o = sp_base_i - SP_W'(beat_i) - SP_W'(1);
            case (beat_i)
                2'd0:    data_o = {8'h00, top_byte};
                2'd1:    data_o = {8'h00, flg_lo};
                2'd2:    data_o = {8'h00, pc_mid};
                default: data_o = {8'h00, pc_lo};
            endcase
            last_o = (beat_i == 2'd3);
        end
    end
endmodule

// File: rtl/irq_ctx_saver.sv
module irq_ctx_saver
    import ctx_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int SWI_W  = 6,
    parameter int SWI_LO = 32,
    parameter int SWI_HI = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              swi_valid_i,
    input  logic [SWI_W-1:0]  swi_num_i,
    input  logic              ustk_sel_i,
    input  logic [SP_W-1:0]   isp_i,
    input  logic [SP_W-1:0]   usp_i,
    input  logic [15:0]       flg_i,
    input  logic [19:0]       pc_i,
    output logic              mem_wr_o,
    output logic [SP_W-1:0]   mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    output logic              mem_word_o,
    input  logic              mem_rdy_i,
    output logic              done_o,
    output logic [SP_W-1:0]   sp_wb_o,
    output logic              sp_wb_user_o
);
    typedef struct packed {
        phase_e             phase;
        logic [SP_W-1:0]    sp;
        logic               odd;
        logic               user;
        logic [FLG_W-1:0]   flg;
        logic [PC_W-1:0]    pc;
        logic [BEAT_W-1:0]  beat;
        logic               done;
    } state_t;

    state_t st_q, st_d;

    logic            sel_user;
    logic [SP_W-1:0] sel_sp;
    logic            beat_last;

    ctx_sp_select #(
        .SP_W   (SP_W),
        .SWI_W  (SWI_W),
        .SWI_LO (SWI_LO),
        .SWI_HI (SWI_HI)
    ) sel_i (
        .swi_valid_i (swi_valid_i),
        .swi_num_i   (swi_num_i),
        .ustk_sel_i  (ustk_sel_i),
        .isp_i       (isp_i),
        .usp_i       (usp_i),
        .use_user_o  (sel_user),
        .sp_o        (sel_sp)
    );

    ctx_beat_gen #(
        .SP_W (SP_W)
    ) beat_i (
        .sp_base_i (st_q.sp),
        .odd_i     (st_q.odd),
        .beat_i    (st_q.beat),
        .flg_i     (st_q.flg),
        .pc_i      (st_q.pc),
        .addr_o    (mem_addr_o),
        .data_o    (mem_wdata_o),
        .word_o    (mem_word_o),
        .last_o    (beat_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (accept_i) begin
                    st_d.phase = PH_WRITE;
                    st_d.sp    = sel_sp;
                    st_d.odd   = sel_sp[0];
                    st_d.user  = sel_user;
                    st_d.flg   = flg_i;
                    st_d.pc    = pc_i;
                    st_d.beat  = '0;
                end
            end
            default: begin
                if (mem_rdy_i) begin
                    if (beat_last) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.beat = st_q.beat + BEAT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_wr_o     = (st_q.phase == PH_WRITE);
    assign done_o       = st_q.done;
    assign sp_wb_o      = st_q.sp - SP_W'(4);
    assign sp_wb_user_o = st_q.user;
endmodule

// File: rtl/irq_ctx_saver_chk.sv
module irq_ctx_saver_chk #(
    parameter int SP_W  = 16,
    parameter int SWI_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept_i,
    input logic             mem_wr_o,
    input logic [SP_W-1:0]  mem_addr_o,
    input logic [15:0]      mem_wdata_o,
    input logic             mem_word_o,
    input logic             mem_rdy_i,
    input logic             done_o,
    input logic [SP_W-1:0]  sp_wb_o
);
    p_word_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_word_o) |-> (mem_addr_o[0] == 1'b0));

    p_byte_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_word_o) |-> (mem_wdata_o[15:8] == 8'h00));

    p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_rdy_i) |=> (mem_wr_o && $stable(mem_addr_o)
            && $stable(mem_wdata_o) && $stable(mem_word_o)));

    p_descending_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_rdy_i) |=> (!mem_wr_o ||
            ((mem_word_o == $past(mem_word_o)) &&
             (mem_addr_o == $past(mem_addr_o) - (mem_word_o ? SP_W'(2) : SP_W'(1))))));

    p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(mem_wr_o) && $past(mem_rdy_i) && !mem_wr_o));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_sp_is_last_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sp_wb_o == $past(mem_addr_o)));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_rdy_i && accept_i) |=> mem_wr_o);
endmodule

bind irq_ctx_saver irq_ctx_saver_chk #(.SP_W(SP_W), .SWI_W(SWI_W)) chk_i (.*);

// File: tb/irq_ctx_saver_tb_top.sv
module irq_ctx_saver_tb_top;
    localparam int SP_W  = 16;
    localparam int SWI_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             accept_i = 1'b0;
    logic             swi_valid_i = 1'b0;
    logic [SWI_W-1:0] swi_num_i = '0;
    logic             ustk_sel_i = 1'b0;
    logic [SP_W-1:0]  isp_i = '0;
    logic [SP_W-1:0]  usp_i = '0;
    logic [15:0]      flg_i = '0;
    logic [19:0]      pc_i = '0;
    logic             mem_wr_o;
    logic [SP_W-1:0]  mem_addr_o;
    logic [15:0]      mem_wdata_o;
    logic             mem_word_o;
    logic             mem_rdy_i = 1'b0;
    logic             done_o;
    logic [SP_W-1:0]  sp_wb_o;
    logic             sp_wb_user_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_ctx_saver #(.SP_W(SP_W), .SWI_W(SWI_W)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_save(input logic [SP_W-1:0] isp, input logic [SP_W-1:0] usp,
                            input bit swv, input int num, input bit u,
                            input logic [15:0] flg, input logic [19:0] pc,
                            input int stall, input bit disturb);
        logic [SP_W-1:0] ea[4];
        logic [15:0]     ed[4];
        logic [SP_W-1:0] sp;
        logic [7:0]      topb;
        bit              user, ew;
        int              nb, k, waited, guard;
        user = swv && (num >= 32) && (num <= 63) && u;
        sp   = user ? usp : isp;
        topb = {flg[15:12], pc[19:16]};
        if (sp[0] == 1'b0) begin
            nb = 2; ew = 1'b1;
            ea[0] = sp - 16'd2; ed[0] = {topb, flg[7:0]};
            ea[1] = sp - 16'd4; ed[1] = pc[15:0];
        end else begin
            nb = 4; ew = 1'b0;
            ea[0] = sp - 16'd1; ed[0] = {8'h00, topb};
            ea[1] = sp - 16'd2; ed[1] = {8'h00, flg[7:0]};
            ea[2] = sp - 16'd3; ed[2] = {8'h00, pc[15:8]};
            ea[3] = sp - 16'd4; ed[3] = {8'h00, pc[7:0]};
        end
        @(negedge clk);
        isp_i = isp; usp_i = usp; swi_valid_i = swv; swi_num_i = SWI_W'(num);
        ustk_sel_i = u; flg_i = flg; pc_i = pc; accept_i = 1'b1; mem_rdy_i = 1'b0;
        k = 0; waited = 0; guard = 0;
        while (k < nb && guard < 64) begin
            @(negedge clk);
            guard++;
            accept_i = disturb && mem_wr_o;
            if (disturb) begin
                flg_i = ~flg; pc_i = ~pc; isp_i = ~isp; usp_i = ~usp; ustk_sel_i = ~u;
            end
            chk(mem_wr_o, "R6 strobe", {31'd0, mem_wr_o}, 32'd1);
            chk(!done_o, "R7 no early done", {31'd0, done_o}, 32'd0);
            chk(mem_addr_o == ea[k], sp[0] ? "R3 byte address" : "R2 word address",
                {16'd0, mem_addr_o}, {16'd0, ea[k]});
            chk(mem_word_o == ew, "R5 size", {31'd0, mem_word_o}, {31'd0, ew});
            chk(mem_wdata_o == ed[k], "R4 image data", {16'd0, mem_wdata_o}, {16'd0, ed[k]});
            if (waited >= stall) begin
                mem_rdy_i = 1'b1; waited = 0; k++;
            end else begin
                mem_rdy_i = 1'b0; waited++;
            end
        end
        @(negedge clk);
        accept_i = 1'b0; mem_rdy_i = 1'b0;
        chk(done_o, "R7 done pulse", {31'd0, done_o}, 32'd1);
        chk(!mem_wr_o, "R7 no write with done", {31'd0, mem_wr_o}, 32'd0);
        chk(sp_wb_o == sp - 16'd4, "R8 pointer minus 4", {16'd0, sp_wb_o}, {16'd0, sp - 16'd4});
        chk(sp_wb_user_o == user, "R1 pointer select", {31'd0, sp_wb_user_o}, {31'd0, user});
        @(negedge clk);
        chk(!done_o, "R7 single pulse", {31'd0, done_o}, 32'd0);
        chk(!mem_wr_o, "R9 no restart", {31'd0, mem_wr_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_wr_o, "R10 reset no write", {31'd0, mem_wr_o}, 32'd0);
        chk(!done_o, "R10 reset no done", {31'd0, done_o}, 32'd0);
        // R1 sweep over every number and both flags, R2/R3 by parity
        for (int sv = 0; sv < 2; sv++) begin
            for (int uu = 0; uu < 2; uu++) begin
                for (int n = 0; n < 64; n++) begin
                    run_save(16'h1000 + 16'(n * 3 + uu), 16'h8001 + 16'(n * 5 + sv),
                             sv[0], n, uu[0],
                             16'(16'hA5C3 ^ (n * 257)), 20'(20'h9_1234 + n * 4099),
                             (n + uu) % 3, 1'b0);
                end
            end
        end
        // R8 wrap below zero, R9 disturbance during the writes
        run_save(16'h0002, 16'h0000, 1'b0, 0, 1'b0, 16'hF00F, 20'hABCDE, 1, 1'b1);
        run_save(16'h0001, 16'h0000, 1'b0, 0, 1'b0, 16'h1234, 20'h56789, 2, 1'b1);
        run_save(16'h0000, 16'h0003, 1'b1, 40, 1'b1, 16'h8001, 20'hF0F0F, 0, 1'b1);
        run_save(16'h7FFF, 16'h4444, 1'b1, 63, 1'b1, 16'hFFFF, 20'hFFFFF, 3, 1'b1);
        run_save(16'h2222, 16'h3333, 1'b1, 31, 1'b1, 16'h0000, 20'h00000, 0, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule